// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a real address by walking a tree of 64-bit table entries held in memory. An outside controller supplies the root table base, the number of index bits the root level uses and the total number of address bits the tree covers, and then pulses `start`. The walker then works through the levels. At each level it checks that the geometry is allowed and forms the entry address from the effective address. It reads the entry through a simple request/response port with a single read in flight. It then either moves down to the next table or stops on a leaf.

When the walk ends, a one-cycle `done` pulse appears together with a fault cause. On success the block also returns the real address, the leaf entry, the address the leaf was read from and the page-size shift. The page size follows from how many address bits the levels consumed. A directory base that is not aligned to its table size has its low bits cleared, and the walk goes on without a fault. All results stay on the outputs until the next accepted start.

Entry layout: bit 63 is the valid flag and bit 62 is the leaf flag. In a directory entry, bits [4:0] give the index width of the next level and bits [55:8] give the next table base. In a leaf, bits [55:12] give the page frame.

Top module: `radix_walker`

## Requirements
- R1: After reset, `busy`, `done` and `memReqValid` are 0 and `faultCause` is 0 (none).
- R2: At each level the read address is the aligned level base plus 8 times the index. The index is (effAddr >> (remaining bits - index bits)) masked to the index bit count. Every read address is 8-byte aligned.
- R3: A level base is aligned to 2^(index bits + 3) bytes by clearing its low bits, both for the root base and for a base taken from a directory entry. A misaligned base raises no fault.
- R4: The level geometry is checked before each read. Level 0 needs 52 remaining bits and 13 index bits. Levels 1 and 2 need 9 index bits. Level 3 accepts 9 or 5 index bits. Level 4 and deeper are never valid. A failed check ends the walk with `faultCause` = 2 (bad configuration) and issues no read for that level.
- R5: A fetched entry with bit 63 clear ends the walk with `faultCause` = 1 (no entry).
- R6: A valid entry with bit 62 clear is a directory. The remaining bit count drops by the current index width, the next index width is taken from entry bits [4:0], and the next base is taken from entry bits [55:8].
- R7: The first valid entry with bit 62 set ends the walk with `faultCause` = 0. `pageShift` is the remaining bit count after that level. `realAddr` is entry bits [55:12] with its low `pageShift` bits replaced by those of `effAddr`. `leafEntry` and `entryAddr` give the leaf and its address.
- R8: `memReqValid` is a one-cycle pulse, and no new request is issued until the response to the previous one has returned.
- R9: `start` is ignored while `busy` is high, including the cycle in which `done` is high.
- R10: `done` is high for exactly one cycle per walk. `faultCause`, `realAddr`, `pageShift`, `leafEntry` and `entryAddr` then stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| effAddr | input | 64 | Effective address to translate |
| rootBase | input | 64 | Root table base address |
| rootIdxBits | input | 5 | Index width of the root level |
| addrSpaceBits | input | 7 | Total address bits covered by the tree |
| memReqValid | output | 1 | Read request strobe |
| memReqAddr | output | 64 | Read request address |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 64 | Read response entry |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| faultCause | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| realAddr | output | 64 | Translated address |
| leafEntry | output | 64 | Last fetched entry |
| entryAddr | output | 64 | Address of the last fetched entry |
| pageShift | output | 7 | log2 of the page size |

## Verification
Two events can land on the same edge: a new `start` can arrive in the very cycle that reports the end of the previous walk, and a fresh start can be offered in the middle of a walk. The bench raises `start` in the `done` cycle and in the middle of a long walk, each time with a different address. It then judges the result by three things: `busy` falls back low, no further memory request is counted, and the held result still matches the first walk. Realignment of a misaligned base and index extraction also share one cycle, and these are judged by the read addresses the memory model records.

// File: rtl/walker_pkg.sv
package walker_pkg;

  localparam int ENTRY_W = 64;
  localparam int VALID_POS = 63;
  localparam int LEAF_POS = 62;
  localparam int NEXT_BITS_W = 5;
  localparam logic [ENTRY_W-1:0] BASE_FIELD = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [ENTRY_W-1:0] FRAME_FIELD = 64'h00FF_FFFF_FFFF_F000;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_NO_ENTRY = 2'd1,
    CAUSE_BAD_CFG  = 2'd2
  } causeT;

  typedef struct packed {
    logic load;
    logic issue;
    logic capture;
    logic descend;
    logic finishLeaf;
    logic faultNoEntry;
    logic faultBadCfg;
  } strobeT;

endpackage

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   levelOk,
  input  logic   memRspValid,
  input  logic   entryValid,
  input  logic   entryLeaf,
  output strobeT strobe,
  output logic   memReqValid,
  output logic   busy,
  output logic   done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT, ST_EVAL, ST_FINISH
  } stateT;

  stateT stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateD = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (levelOk) begin
          strobe.issue = 1'b1;
          stateD = ST_REQ;
        end else begin
          strobe.faultBadCfg = 1'b1;
          stateD = ST_FINISH;
        end
      end
      ST_REQ: stateD = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.capture = 1'b1;
          stateD = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!entryValid) begin
          strobe.faultNoEntry = 1'b1;
          stateD = ST_FINISH;
        end else if (entryLeaf) begin
          strobe.finishLeaf = 1'b1;
          stateD = ST_FINISH;
        end else begin
          strobe.descend = 1'b1;
          stateD = ST_CHECK;
        end
      end
      ST_FINISH: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign memReqValid = (stateQ == ST_REQ);
  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_FINISH);

endmodule

// File: rtl/walker_dp.sv
module walker_dp
  import walker_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_BITS = 13,
  parameter int MID_BITS = 9,
  parameter int ALT_BITS = 5,
  parameter int MAX_LEVEL = 3,
  localparam int SHIFT_W = $clog2(ADDR_W) + 1,
  localparam int LEVEL_W = $clog2(MAX_LEVEL + 2)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strobe,
  input  logic [ADDR_W-1:0]      effAddr,
  input  logic [ADDR_W-1:0]      rootBase,
  input  logic [NEXT_BITS_W-1:0] rootIdxBits,
  input  logic [SHIFT_W-1:0]     addrSpaceBits,
  input  logic [ENTRY_W-1:0]     memRspData,
  output logic                   levelOk,
  output logic                   entryValid,
  output logic                   entryLeaf,
  output logic [ADDR_W-1:0]      entryAddr,
  output logic [ADDR_W-1:0]      realAddr,
  output logic [ENTRY_W-1:0]     leafEntry,
  output logic [SHIFT_W-1:0]     pageShift,
  output logic [1:0]             faultCause
);

  logic [ADDR_W-1:0]      eaQ, baseQ, entryAddrQ, realAddrQ;
  logic [NEXT_BITS_W-1:0] nlsQ;
  logic [SHIFT_W-1:0]     remainQ, pageShiftQ;
  logic [LEVEL_W-1:0]     levelQ;
  logic [ENTRY_W-1:0]     entryQ;
  causeT                  causeQ;

  // Per-level geometry table, one comparator set per level
  logic [MAX_LEVEL:0] okVec;
  for (genvar lv = 0; lv <= MAX_LEVEL; lv++) begin : g_level
    if (lv == 0) begin : g_root
      assign okVec[lv] = (remainQ == SHIFT_W'(ROOT_SIZE)) &&
                         (nlsQ == NEXT_BITS_W'(ROOT_BITS));
    end else if (lv < MAX_LEVEL) begin : g_mid
      assign okVec[lv] = (nlsQ == NEXT_BITS_W'(MID_BITS));
    end else begin : g_last
      assign okVec[lv] = (nlsQ == NEXT_BITS_W'(MID_BITS)) ||
                         (nlsQ == NEXT_BITS_W'(ALT_BITS));
    end
  end

  always_comb begin
    levelOk = 1'b0;
    for (int lv = 0; lv <= MAX_LEVEL; lv++) begin
      if (levelQ == LEVEL_W'(lv)) levelOk = okVec[lv];
    end
  end

  // Index extraction and base realignment
  logic [SHIFT_W-1:0] nlsWide, shAmt, remainAfter;
  logic [ADDR_W-1:0]  idxMask, alignMask, idxVal, entryAddrNext, pageMask;
  logic [ADDR_W-1:0]  nextBase, frameBits;

  always_comb begin
    nlsWide       = SHIFT_W'(nlsQ);
    shAmt         = remainQ - nlsWide;
    idxMask       = (ADDR_W'(1) << nlsWide) - ADDR_W'(1);
    alignMask     = (ADDR_W'(1) << (nlsWide + SHIFT_W'(3))) - ADDR_W'(1);
    idxVal        = (eaQ >> shAmt) & idxMask;
    entryAddrNext = (baseQ & ~alignMask) + (idxVal << 3);
    remainAfter   = remainQ - nlsWide;
    pageMask      = (ADDR_W'(1) << remainAfter) - ADDR_W'(1);
    nextBase      = ADDR_W'(entryQ & BASE_FIELD);
    frameBits     = ADDR_W'(entryQ & FRAME_FIELD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ        <= '0;
      baseQ      <= '0;
      nlsQ       <= '0;
      remainQ    <= '0;
      levelQ     <= '0;
      entryAddrQ <= '0;
      entryQ     <= '0;
      realAddrQ  <= '0;
      pageShiftQ <= '0;
      causeQ     <= CAUSE_NONE;
    end else begin
      if (strobe.load) begin
        eaQ        <= effAddr;
        baseQ      <= rootBase;
        nlsQ       <= rootIdxBits;
        remainQ    <= addrSpaceBits;
        levelQ     <= '0;
        entryAddrQ <= '0;
        entryQ     <= '0;
        realAddrQ  <= '0;
        pageShiftQ <= '0;
        causeQ     <= CAUSE_NONE;
      end
      if (strobe.issue) entryAddrQ <= entryAddrNext;
      if (strobe.capture) entryQ <= memRspData;
      if (strobe.descend) begin
        remainQ <= remainAfter;
        nlsQ    <= entryQ[NEXT_BITS_W-1:0];
        baseQ   <= nextBase;
        levelQ  <= levelQ + LEVEL_W'(1);
      end
      if (strobe.finishLeaf) begin
        remainQ    <= remainAfter;
        pageShiftQ <= remainAfter;
        realAddrQ  <= (frameBits & ~pageMask) | (eaQ & pageMask);
      end
      if (strobe.faultNoEntry) causeQ <= CAUSE_NO_ENTRY;
      if (strobe.faultBadCfg)  causeQ <= CAUSE_BAD_CFG;
    end
  end

  assign entryValid = entryQ[VALID_POS];
  assign entryLeaf  = entryQ[LEAF_POS];
  assign entryAddr  = entryAddrQ;
  assign realAddr   = realAddrQ;
  assign leafEntry  = entryQ;
  assign pageShift  = pageShiftQ;
  assign faultCause = causeQ;

endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import walker_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int ROOT_SIZE = 52,
  parameter int ROOT_BITS = 13,
  parameter int MID_BITS = 9,
  parameter int ALT_BITS = 5,
  parameter int MAX_LEVEL = 3,
  localparam int SHIFT_W = $clog2(ADDR_W) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      effAddr,
  input  logic [ADDR_W-1:0]      rootBase,
  input  logic [NEXT_BITS_W-1:0] rootIdxBits,
  input  logic [SHIFT_W-1:0]     addrSpaceBits,
  output logic                   memReqValid,
  output logic [ADDR_W-1:0]      memReqAddr,
  input  logic                   memRspValid,
  input  logic [ENTRY_W-1:0]     memRspData,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             faultCause,
  output logic [ADDR_W-1:0]      realAddr,
  output logic [ENTRY_W-1:0]     leafEntry,
  output logic [ADDR_W-1:0]      entryAddr,
  output logic [SHIFT_W-1:0]     pageShift
);

  strobeT strobe;
  logic   levelOk, entryValid, entryLeaf;

  walker_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .levelOk     (levelOk),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .entryLeaf   (entryLeaf),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done)
  );

  walker_dp #(
    .ADDR_W    (ADDR_W),
    .ROOT_SIZE (ROOT_SIZE),
    .ROOT_BITS (ROOT_BITS),
    .MID_BITS  (MID_BITS),
    .ALT_BITS  (ALT_BITS),
    .MAX_LEVEL (MAX_LEVEL)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .effAddr       (effAddr),
    .rootBase      (rootBase),
    .rootIdxBits   (rootIdxBits),
    .addrSpaceBits (addrSpaceBits),
    .memRspData    (memRspData),
    .levelOk       (levelOk),
    .entryValid    (entryValid),
    .entryLeaf     (entryLeaf),
    .entryAddr     (entryAddr),
    .realAddr      (realAddr),
    .leafEntry     (leafEntry),
    .pageShift     (pageShift),
    .faultCause    (faultCause)
  );

  assign memReqAddr = entryAddr;

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int SHIFT_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               memReqValid,
  input logic [ADDR_W-1:0]  memReqAddr,
  input logic               memRspValid,
  input logic [1:0]         faultCause,
  input logic [ADDR_W-1:0]  realAddr,
  input logic [SHIFT_W-1:0] pageShift
);

  logic pendQ;
  always_ff @(posedge clk) begin
    if (!rstN)            pendQ <= 1'b0;
    else if (memReqValid) pendQ <= 1'b1;
    else if (memRspValid) pendQ <= 1'b0;
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid) else $error("req pulse");                     // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !pendQ) else $error("overlap");                             // R8
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[2:0] == 3'd0)) else $error("align");            // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done pulse");                                  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(faultCause) && $stable(realAddr) &&
                           $stable(pageShift))) else $error("hold");            // R10
  AST_DONE_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !busy) else $error("restart");                          // R9
  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (faultCause != 2'd3)) else $error("cause code");                   // R4
  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (done && faultCause == 2'd0) |-> (pageShift >= SHIFT_W'(12) &&
                                      pageShift <= SHIFT_W'(39))) else $error("shift"); // R7

endmodule

bind radix_walker radix_walker_chk #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .faultCause  (faultCause),
  .realAddr    (realAddr),
  .pageShift   (pageShift)
);

// File: tb/tb_radix_walker.sv
module tb_radix_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] effAddr = '0, rootBase = '0;
  logic [4:0]  rootIdxBits = '0;
  logic [6:0]  addrSpaceBits = '0;
  logic        memReqValid, memRspValid = 1'b0;
  logic [63:0] memReqAddr, memRspData = '0;
  logic        busy, done;
  logic [1:0]  faultCause;
  logic [63:0] realAddr, leafEntry, entryAddr;
  logic [6:0]  pageShift;

  always #10 clk = ~clk;

  radix_walker dut (
    .clk(clk), .rstN(rstN), .start(start), .effAddr(effAddr),
    .rootBase(rootBase), .rootIdxBits(rootIdxBits), .addrSpaceBits(addrSpaceBits),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .busy(busy), .done(done), .faultCause(faultCause), .realAddr(realAddr),
    .leafEntry(leafEntry), .entryAddr(entryAddr), .pageShift(pageShift)
  );

  int nChecks = 0, nFails = 0;
  int reqCount = 0, overlapCount = 0, latency = 1;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] lvlBase [5];
  logic [4:0]  lvlBits [5];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: responds after 'latency' negedges, tracks overlap
  initial begin
    int pend = 0;
    bit prevReq = 0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          memRspValid = 1'b1;
          memRspData = mem.exists(memReqAddr) ? mem[memReqAddr] : 64'd0;
        end
      end
      if (memReqValid) begin
        if (pend > 0 || prevReq) overlapCount++;
        reqCount++;
        pend = latency;
      end
      prevReq = memReqValid;
    end
  end

  function automatic logic [63:0] idxOf(input logic [63:0] ea, input int remain, input int bits);
    return (ea >> (remain - bits)) & ((64'd1 << bits) - 64'd1);
  endfunction

  function automatic logic [63:0] alignOf(input logic [63:0] b, input int bits);
    return b & ~((64'd1 << (bits + 3)) - 64'd1);
  endfunction

  // Build a chain of 'depth' entries; leaf at the last, or zero entry at 'badAt'
  task automatic build(input logic [63:0] ea, input int depth, input logic [63:0] pa,
                       input int badAt, output logic [63:0] expAddr,
                       output int expShift, output logic [63:0] expReal);
    int remain = 52;
    mem.delete();
    expAddr = '0;
    for (int k = 0; k < depth; k++) begin
      logic [63:0] a;
      a = alignOf(lvlBase[k], lvlBits[k]) + (idxOf(ea, remain, lvlBits[k]) << 3);
      remain -= lvlBits[k];
      expAddr = a;
      if (k == badAt) begin
        mem[a] = 64'd0;
        break;
      end
      if (k == depth - 1)
        mem[a] = (64'd1 << 63) | (64'd1 << 62) | (pa & 64'h00FF_FFFF_FFFF_F000);
      else
        mem[a] = (64'd1 << 63) | (lvlBase[k+1] & 64'h00FF_FFFF_FFFF_FF00) | 64'(lvlBits[k+1]);
    end
    expShift = remain;
    expReal = (pa & 64'h00FF_FFFF_FFFF_F000 & ~((64'd1 << remain) - 64'd1)) |
              (ea & ((64'd1 << remain) - 64'd1));
  endtask

  task automatic doWalk(input logic [63:0] ea, input logic [6:0] size, input int lat,
                        input bit pokeBusy, input bit pokeDone, output int nReq);
    int base = reqCount;
    latency = lat;
    @(negedge clk);
    effAddr = ea; rootBase = lvlBase[0]; rootIdxBits = lvlBits[0]; addrSpaceBits = size;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pokeBusy) begin
      effAddr = ~ea;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      effAddr = ea;
    end
    while (!done) @(negedge clk);
    if (pokeDone) begin
      start = 1'b1;
      effAddr = 64'h0;
      @(negedge clk);
      start = 1'b0;
      check(!busy, "R9 start in done cycle ignored (busy)", 64'(busy), 64'd0);
    end else begin
      @(negedge clk);
      check(!done, "R10 done single cycle", 64'(done), 64'd0);
    end
    nReq = reqCount - base;
  endtask

  task automatic setGeom(input int b0, input int b1, input int b2, input int b3, input int b4);
    lvlBits[0] = 5'(b0); lvlBits[1] = 5'(b1); lvlBits[2] = 5'(b2);
    lvlBits[3] = 5'(b3); lvlBits[4] = 5'(b4);
    lvlBase[0] = 64'h0010_0000; lvlBase[1] = 64'h0020_0000; lvlBase[2] = 64'h0030_0000;
    lvlBase[3] = 64'h0040_0000; lvlBase[4] = 64'h0050_0000;
  endtask

  task automatic t_reset;
    check(!busy && !done && !memReqValid, "R1 idle after reset", {61'd0, busy, done, memReqValid}, 64'd0);
    check(faultCause == 2'd0, "R1 cause none after reset", 64'(faultCause), 64'd0);
  endtask

  task automatic t_four_level;
    logic [63:0] ea = 64'h000A_BCDE_F123_4567, ea2, expA, expR;
    int sh, n;
    setGeom(13, 9, 9, 9, 9);
    build(ea, 4, 64'h0000_00AB_CDE0_0000, -1, expA, sh, expR);
    doWalk(ea, 7'd52, 2, 0, 0, n);
    check(faultCause == 2'd0, "R7 four-level cause", 64'(faultCause), 64'd0);
    check(realAddr == expR, "R7 four-level realAddr", realAddr, expR);
    check(pageShift == 7'(sh), "R6 four-level pageShift", 64'(pageShift), 64'(sh));
    check(entryAddr == expA, "R2 four-level leaf address", entryAddr, expA);
    check(leafEntry == mem[expA], "R7 leaf entry", leafEntry, mem[expA]);
    check(n == 4, "R6 four reads", 64'(n), 64'd4);
    repeat (6) @(negedge clk);
    check(realAddr == expR && faultCause == 2'd0 && !done, "R10 result held", realAddr, expR);
    ea2 = 64'h0003_3FFF_0000_1FFF;
    build(ea2, 4, 64'h0000_0012_3456_7000, -1, expA, sh, expR);
    doWalk(ea2, 7'd52, 1, 0, 0, n);
    check(realAddr == expR, "R2 second pattern realAddr", realAddr, expR);
  endtask

  task automatic t_alt_last;
    logic [63:0] ea = 64'h000F_0F0F_1234_ABCD, expA, expR;
    int sh, n;
    setGeom(13, 9, 9, 5, 9);
    build(ea, 4, 64'h0000_0077_0000_0000, -1, expA, sh, expR);
    doWalk(ea, 7'd52, 3, 0, 0, n);
    check(faultCause == 2'd0 && pageShift == 7'd16, "R4 level3 five bits accepted", 64'(pageShift), 64'd16);
    check(realAddr == expR, "R7 16-bit page realAddr", realAddr, expR);
  endtask

  task automatic t_leaf_level1;
    logic [63:0] ea = 64'h0001_2345_6789_ABCD, expA, expR;
    int sh, n;
    setGeom(13, 9, 9, 9, 9);
    build(ea, 2, 64'h0000_0040_0000_0000, -1, expA, sh, expR);
    doWalk(ea, 7'd52, 1, 0, 0, n);
    check(pageShift == 7'd30 && n == 2, "R7 leaf at level 1 shift", 64'(pageShift), 64'd30);
    check(realAddr == expR, "R7 leaf at level 1 realAddr", realAddr, expR);
  endtask

  task automatic t_misaligned;
    logic [63:0] ea = 64'h0008_8888_4444_2222, expA, expR;
    int sh, n;
    setGeom(13, 9, 9, 9, 9);
    lvlBase[0] = 64'h0010_0108;
    lvlBase[2] = 64'h0030_0F00;
    build(ea, 4, 64'h0000_0001_0000_0000, -1, expA, sh, expR);
    doWalk(ea, 7'd52, 1, 0, 0, n);
    check(faultCause == 2'd0, "R3 misaligned base no fault", 64'(faultCause), 64'd0);
    check(entryAddr == expA && realAddr == expR, "R3 realigned walk address", entryAddr, expA);
  endtask

  task automatic t_bad_root;
    logic [63:0] expA, expR;
    int sh, n;
    setGeom(13, 9, 9, 9, 9);
    build(64'h1234, 4, 64'h0, -1, expA, sh, expR);
    doWalk(64'h1234, 7'd48, 1, 0, 0, n);
    check(faultCause == 2'd2, "R4 root size 48 bad config", 64'(faultCause), 64'd2);
    check(n == 0, "R4 no read on bad root", 64'(n), 64'd0);
    setGeom(12, 9, 9, 9, 9);
    doWalk(64'h1234, 7'd52, 1, 0, 0, n);
    check(faultCause == 2'd2 && n == 0, "R4 root 12 bits bad config", 64'(faultCause), 64'd2);
  endtask

  task automatic t_bad_mid;
    logic [63:0] ea = 64'h0000_1111_2222_3333, expA, expR;
    int sh, n;
    setGeom(13, 8, 9, 9, 9);
    build(ea, 4, 64'h0, -1, expA, sh, expR);
    doWalk(ea, 7'd52, 1, 0, 0, n);
    check(faultCause == 2'd2 && n == 1, "R4 level1 eight bits bad config", 64'(n), 64'd1);
    setGeom(13, 9, 9, 9, 9);
    build(ea, 5, 64'h0, -1, expA, sh, expR);
    doWalk(ea, 7'd52, 1, 0, 0, n);
    check(faultCause == 2'd2 && n == 4, "R4 fifth level invalid", 64'(n), 64'd4);
  endtask

  task automatic t_no_entry;
    logic [63:0] ea = 64'h0005_5555_AAAA_5555, expA, expR;
    int sh, n;
    setGeom(13, 9, 9, 9, 9);
    build(ea, 4, 64'h0, 2, expA, sh, expR);
    doWalk(ea, 7'd52, 2, 0, 0, n);
    check(faultCause == 2'd1, "R5 invalid entry cause", 64'(faultCause), 64'd1);
    check(n == 3 && entryAddr == expA, "R5 stops at invalid entry", entryAddr, expA);
  endtask

  task automatic t_start_ignored;
    logic [63:0] ea = 64'h0002_4680_1357_9BDF, expA, expR;
    int sh, n;
    setGeom(13, 9, 9, 9, 9);
    build(ea, 4, 64'h0000_0099_9999_9000, -1, expA, sh, expR);
    doWalk(ea, 7'd52, 2, 1, 1, n);
    check(realAddr == expR && n == 4, "R9 start while busy ignored", realAddr, expR);
    repeat (4) @(negedge clk);
    check(reqCount == 0 || !busy, "R9 no restart after done", 64'(busy), 64'd0);
    check(realAddr == expR, "R10 result held after ignored start", realAddr, expR);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_four_level();
    t_alt_last();
    t_leaf_level1();
    t_misaligned();
    t_bad_root();
    t_bad_mid();
    t_no_entry();
    t_start_ignored();
    check(overlapCount == 0, "R8 one request in flight, one-cycle pulses", 64'(overlapCount), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule